// File: doc/BRIEF.md
# Serial RAM Download Loader

This block loads a program image into on-chip RAM over a serial line. An upstream receiver delivers whole bytes, each marked by a one-cycle valid strobe. The loader writes every accepted byte in the same cycle to the next RAM location, starting at the RAM base.

Before the first byte arrives, the loader waits with no time limit. Once loading has begun, the download ends in one of two ways, whichever comes first:
- a set number of character-time ticks passes with no new byte, or
- the byte for the top RAM address is written.

When the download ends, the loader raises a single-cycle start pulse and presents the entry address for the core that takes over. From then on, received bytes are dropped until the next reset.

The serial transmit pin is handled as open-drain. A zero bit turns the driver on and pulls the pin low. A one bit releases the pin, and an external pullup must hold the line high.

Top module: `ram_loader`

## Requirements
- R1: After reset, `ram_we_o`, `start_o` and `done_o` are 0, and the first accepted byte is written at address `RAM_BASE`.
- R2: Each `rx_valid_i` pulse accepted before completion gives `ram_we_o`=1 in that same cycle. `ram_wdata_o` equals `rx_data_i`, and the addresses run `RAM_BASE`, `RAM_BASE+1`, ... in the order the bytes arrive.
- R3: Before the first byte, `char_tick_i` pulses have no effect: `done_o` and `start_o` stay 0 however many ticks arrive.
- R4: After the first byte, the `IDLE_CHARS`-th tick (default 4) counted since the most recent byte, with no byte in between, raises `start_o` in the cycle after that tick is sampled.
- R5: An accepted byte restarts the idle count. This includes a byte that arrives in the same cycle as a tick, which then does not count.
- R6: Writing the byte at address `RAM_BASE+RAM_DEPTH-1` raises `start_o` in the next cycle, so at most `RAM_DEPTH` bytes are ever written.
- R7: `start_o` is high for exactly one cycle. `done_o` rises with it and stays high until reset, and `entry_addr_o` equals `RAM_BASE`.
- R8: Once `done_o` is 1, `rx_valid_i` pulses give no RAM write (`ram_we_o` stays 0).
- R9: The transmit pin is open-drain: `tx_o` is always 0, and `tx_oe_o` is 1 exactly when `tx_bit_i` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_valid_i | input | 1 | One-cycle strobe: a received byte is present |
| rx_data_i | input | 8 | Received byte |
| char_tick_i | input | 1 | One-cycle pulse per character time |
| tx_bit_i | input | 1 | Serial transmit bit from the transmitter |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | ADDR_W | RAM write address |
| ram_wdata_o | output | 8 | RAM write data |
| tx_o | output | 1 | Transmit pin value (always low) |
| tx_oe_o | output | 1 | Transmit pin drive enable |
| start_o | output | 1 | One-cycle pulse: hand control to loaded program |
| done_o | output | 1 | Download finished, held until reset |
| entry_addr_o | output | ADDR_W | Entry address for the downstream core |

## Verification
The hardest situation to reach from the ports is a byte and a character tick landing in the same cycle near the end of an idle window. That cycle decides whether the timeout is restarted or fires one tick early. The stimulus first lets three ticks pass after a byte, then drives a byte and a tick together. It then counts out a further full window, checking that `start_o` stays low until the fourth clean tick.

The full-RAM exit is a second hard case. The bench reaches it with a reduced `RAM_DEPTH`, after a fresh reset, by streaming bytes back-to-back with no ticks at all.

// File: rtl/ld_pkg.sv
`timescale 1ns/1ps
package ld_pkg;
  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_LOAD = 2'd1,
    ST_DONE = 2'd2
  } ld_state_e;
endpackage

// File: rtl/ld_wptr.sv
`timescale 1ns/1ps
module ld_wptr #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned RAM_BASE  = 0,
  parameter int unsigned RAM_DEPTH = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              last_o
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(RAM_BASE);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(RAM_BASE + RAM_DEPTH - 1);

  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ptr_q <= BASE_A;
    else if (adv_i && !last_o)  ptr_q <= ptr_q + ADDR_W'(1);
  end

  assign ptr_o  = ptr_q;
  assign last_o = (ptr_q == LAST_A);

  // R2
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !last_o) |=> (ptr_q == $past(ptr_q) + ADDR_W'(1)));
  // R6
  ptr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_q >= BASE_A) && (ptr_q <= LAST_A));
endmodule

// File: rtl/ld_idle.sv
`timescale 1ns/1ps
module ld_idle #(
  parameter int unsigned IDLE_CHARS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clear_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(IDLE_CHARS + 1);
  localparam logic [CW-1:0] TOP = CW'(IDLE_CHARS - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && tick_i && !clear_i && (cnt_q == TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clear_i || expire_o)     cnt_q <= '0;
    else if (run_i && tick_i)         cnt_q <= cnt_q + CW'(1);
  end

  // R5
  idle_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0));
  // R4
  idle_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TOP);
  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clear_i) |=> $stable(cnt_q));
endmodule

// File: rtl/ram_loader.sv
`timescale 1ns/1ps
module ram_loader
  import ld_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned RAM_BASE   = 0,
  parameter int unsigned RAM_DEPTH  = 512,
  parameter int unsigned IDLE_CHARS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              char_tick_i,
  input  logic              tx_bit_i,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [7:0]        ram_wdata_o,
  output logic              tx_o,
  output logic              tx_oe_o,
  output logic              start_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] entry_addr_o
);
  ld_state_e         state_q, state_d;
  logic              start_q;
  logic              accept, last, expire, fire;
  logic [ADDR_W-1:0] ptr;

  assign accept = rx_valid_i && (state_q != ST_DONE);

  ld_wptr #(.ADDR_W(ADDR_W), .RAM_BASE(RAM_BASE), .RAM_DEPTH(RAM_DEPTH)) u_wptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (accept),
    .ptr_o (ptr),
    .last_o(last)
  );

  ld_idle #(.IDLE_CHARS(IDLE_CHARS)) u_idle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (state_q == ST_LOAD),
    .clear_i (accept),
    .tick_i  (char_tick_i),
    .expire_o(expire)
  );

  assign fire = (accept && last) || expire;

  always_comb begin
    state_d = state_q;
    if (fire)        state_d = ST_DONE;
    else if (accept) state_d = ST_LOAD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= fire;
    end
  end

  assign ram_we_o     = accept;
  assign ram_addr_o   = ptr;
  assign ram_wdata_o  = rx_data_i;
  assign start_o      = start_q;
  assign done_o       = (state_q == ST_DONE);
  assign entry_addr_o = ADDR_W'(RAM_BASE);

  // open-drain pin: only ever pulls low
  assign tx_o    = 1'b0;
  assign tx_oe_o = ~tx_bit_i;

  // R7
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  // R7
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  // R7
  start_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> start_o);
  // R3
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_WAIT) && !rx_valid_i) |=> !done_o);
  // R8
  no_late_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !ram_we_o);
endmodule

// File: tb/tb_ram_loader.sv
`timescale 1ns/1ps
module tb_ram_loader;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned BASE   = 256;
  localparam int unsigned DEPTH  = 8;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              rx_valid = 1'b0;
  logic [7:0]        rx_data = '0;
  logic              tick = 1'b0;
  logic              tx_bit = 1'b1;
  logic              ram_we, tx, tx_oe, start, done;
  logic [ADDR_W-1:0] ram_addr, entry_addr;
  logic [7:0]        ram_wdata;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [ADDR_W+7:0] exp_q[$];
  logic [ADDR_W-1:0] exp_addr;

  always #4 clk = ~clk;

  ram_loader #(.ADDR_W(ADDR_W), .RAM_BASE(BASE), .RAM_DEPTH(DEPTH), .IDLE_CHARS(4)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .char_tick_i(tick), .tx_bit_i(tx_bit), .ram_we_o(ram_we), .ram_addr_o(ram_addr),
    .ram_wdata_o(ram_wdata), .tx_o(tx), .tx_oe_o(tx_oe), .start_o(start),
    .done_o(done), .entry_addr_o(entry_addr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pop expected writes as they appear
  always @(negedge clk) begin
    if (rst_ni && ram_we) begin
      if (exp_q.size() == 0) begin
        check(0, "R8", "unexpected write", {ram_addr, ram_wdata}, 0);
      end else begin
        logic [ADDR_W+7:0] e;
        e = exp_q.pop_front();
        check({ram_addr, ram_wdata} == e, "R2", "write addr/data",
              {ram_addr, ram_wdata}, e);
      end
    end
  end

  task automatic send_byte(input logic [7:0] d, input bit expect_wr, input bit with_tick);
    @(posedge clk); #1;
    rx_valid = 1'b1; rx_data = d; tick = with_tick;
    if (expect_wr) begin
      exp_q.push_back({exp_addr, d});
      exp_addr = exp_addr + 1'b1;
    end
  endtask

  task automatic rx_idle();
    @(posedge clk); #1;
    rx_valid = 1'b0; tick = 1'b0;
  endtask

  task automatic tick_pulse();
    @(posedge clk); #1; tick = 1'b1;
    @(posedge clk); #1; tick = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; rx_valid = 1'b0; tick = 1'b0;
    exp_addr = ADDR_W'(BASE);
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    check(!ram_we && !start && !done, "R1", "reset outputs",
          {ram_we, start, done}, 0);
  endtask

  initial begin
    do_reset();
    // R9
    tx_bit = 1'b0; #1;
    check(tx_oe && !tx, "R9", "drive low", {tx_oe, tx}, 2'b10);
    tx_bit = 1'b1; #1;
    check(!tx_oe && !tx, "R9", "release", {tx_oe, tx}, 2'b00);
    // R3: ticks before first byte
    repeat (20) tick_pulse();
    check(!done && !start, "R3", "no timeout before first byte", {done, start}, 0);
    // R1/R2 first byte at base
    send_byte(8'hA0, 1, 0); rx_idle();
    repeat (3) tick_pulse();
    check(!start && !done, "R4", "3 ticks no timeout", {start, done}, 0);
    // R5: new byte restarts count
    send_byte(8'hA1, 1, 0); rx_idle();
    repeat (3) tick_pulse();
    check(!start && !done, "R5", "restart after byte", {start, done}, 0);
    // R5: byte with tick in same cycle
    send_byte(8'hA2, 1, 1); rx_idle();
    repeat (3) tick_pulse();
    check(!start && !done, "R5", "byte+tick restarts", {start, done}, 0);
    tick_pulse();
    check(start == 1'b1, "R4", "timeout start pulse", start, 1);
    check(done == 1'b1, "R7", "done with start", done, 1);
    check(entry_addr == ADDR_W'(BASE), "R7", "entry addr", entry_addr, BASE);
    @(posedge clk); #1;
    check(start == 1'b0 && done, "R7", "one-cycle pulse", {start, done}, 2'b01);
    // R8: bytes after done ignored
    send_byte(8'h55, 0, 0); #1;
    check(!ram_we, "R8", "write after done", ram_we, 0);
    rx_idle();
    send_byte(8'h66, 0, 0); rx_idle();
    repeat (6) tick_pulse();
    check(!start && done, "R7", "done sticky, no second start", {start, done}, 2'b01);
    check(exp_q.size() == 0, "R2", "all writes seen", exp_q.size(), 0);

    // full-RAM exit
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin
      send_byte(8'h10 + 8'(i), 1, 0);
      if (i < DEPTH - 1) begin
        #1 check(!start, "R6", "no early start", start, 0);
      end
    end
    rx_idle();
    check(start == 1'b1, "R6", "start after last address", start, 1);
    check(exp_q.size() == 0, "R6", "all bytes written", exp_q.size(), 0);
    send_byte(8'hEE, 0, 0); #1;
    check(!ram_we, "R8", "write beyond RAM", ram_we, 0);
    rx_idle();
    @(negedge clk);
    check(done && !start, "R7", "held done", {done, start}, 2'b10);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule